// File: doc/BRIEF.md
# Delay Tap Sweep Calibration Controller

This block calibrates the read-capture delay line of a memory interface. It finds the middle of the range of delay settings at which reads succeed. After a start pulse it steps a tap setting upward from zero, one step at a time. The same setting is driven onto every byte-lane delay output. At each setting the block launches an external self-test engine, waits for that engine to report completion, and then judges the reported pass and fail counts.

Across the sweep the block tracks three things: the lowest passing setting, the highest passing setting, and how many settings passed. When the top setting has been judged, it programs the midpoint of the lowest and highest passing settings onto all lanes. If nothing passed, it programs a fixed fallback setting instead. It then pulses a completion flag. The programmed setting, the passing count and a result-valid level stay on the outputs until the next start.

There is no streaming data path, so there is no valid/ready back-pressure. Every pin is a plain control or status signal. The run-count configuration is sampled when a start is accepted. The self-test engine must keep its done bit low until it has been started.

Top module: `tap_sweep_cal`

## Requirements
- R1: One calibration judges every 6-bit tap exactly once, in the order 0, 1, 2 up to 63, starting one self-test per tap. The sweep ends after tap 63 has been judged.
- R2: Before each self-test is started, all four lane outputs carry the tap under test. Lane k occupies bits [6k+5:6k] of `lane_tap_o`. After reset every lane is 0.
- R3: `bist_start_o` rises once per tap and stays high until `bist_status_i[0]` is seen at 1. It is low on the following cycle. It is low after reset.
- R4: The self-test status carries the pass-run count in bits [8:1] and the fail count in bits [16:9]. The required run count is `run_cfg_i[8:1]`, sampled when a start is accepted. Changes to `run_cfg_i` later in the sweep have no effect.
- R5: A tap passes only when the fail count is zero and the pass-run count equals the sampled run count.
- R6: Each passing tap adds one to the passing count. The first passing tap sets both the lowest and the highest pass; later passing taps move only the highest. A new start clears the count and both bounds.
- R7: Until a first pass is found, the lowest-pass register holds the marker value 0xAA55AA55. A window that begins at tap 0 is therefore still recognised.
- R8: With a non-zero passing count, the final tap is (lowest + highest) >> 1, kept to 6 bits.
- R9: With a passing count of zero, the final tap is 8.
- R10: `done_o` is high for exactly one cycle, in the cycle the final tap first appears on all lanes. From then until the next start, `result_valid_o` is 1, `pass_count_o` holds the passing count (0 to 64), and the lanes hold the final tap. After reset, `done_o` and `result_valid_o` are 0.
- R11: A start pulse that arrives while a calibration is under way is ignored. The sweep continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins a calibration when idle |
| run_cfg_i | input | 8 (bits 8:1) | Required pass-run count per tap |
| bist_status_i | input | 17 | Self-test status: bit 0 done, [8:1] passes, [16:9] fails |
| bist_start_o | output | 1 | Self-test launch level |
| lane_tap_o | output | 24 | Four 6-bit lane tap settings |
| done_o | output | 1 | One-cycle completion pulse |
| result_valid_o | output | 1 | Result outputs are meaningful |
| pass_count_o | output | 7 | Number of passing taps in the last calibration |

## Verification
The assertions watch the following on every cycle:
- the tap advancing by exactly one between judgements;
- the launch level dropping right after the done bit;
- all lanes matching the tap under test at each launch;
- the marker staying in place while no tap has passed, and the highest pass never lying below the lowest;
- the completion pulse lasting one cycle, and the lanes holding still while the result is valid;
- the fallback tap appearing whenever the count is zero;
- a start during a sweep never sending the tap back to zero.

Whether the counted window and the midpoint are right depends on stimulus. That is shown only by the bench's scenarios, which pass a modelled self-test over many programmed windows: empty, single-tap at both ends, full-range, and count-mismatch versus nonzero-fail rejection.

// File: rtl/tap_cal_pkg.sv
package tap_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_ARM,
    ST_RUN,
    ST_JUDGE,
    ST_FINAL
  } seq_state_t;

endpackage

// File: rtl/tap_cal_judge.sv
module tap_cal_judge #(
  parameter int CNT_W = 8
) (
  input  logic [2*CNT_W-1:0] counts_i,
  input  logic [CNT_W-1:0]   runs_i,
  output logic               pass_o
);
  logic [CNT_W-1:0] ok_runs;
  logic [CNT_W-1:0] bad_runs;

  // Lower field: passing runs; upper field: failing runs.
  assign ok_runs  = counts_i[CNT_W-1:0];
  assign bad_runs = counts_i[2*CNT_W-1:CNT_W];

  always_comb begin
    pass_o = 1'b0;
    if (bad_runs == '0 && ok_runs == runs_i) pass_o = 1'b1;
  end
endmodule

// File: rtl/tap_cal_window.sv
module tap_cal_window #(
  parameter int                 TAP_W       = 6,
  parameter int                 MARK_W      = 32,
  parameter logic [MARK_W-1:0]  NO_PASS     = 32'hAA55AA55,
  parameter int                 DEFAULT_TAP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             update_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W:0]   count_o,
  output logic [TAP_W-1:0] final_o
);
  localparam logic [TAP_W-1:0] FALLBACK = TAP_W'(DEFAULT_TAP);

  logic [MARK_W-1:0] low_q;
  logic [TAP_W-1:0]  high_q;
  logic [TAP_W:0]    count_q;
  logic [TAP_W:0]    span_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= NO_PASS;
      high_q  <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      low_q   <= NO_PASS;
      high_q  <= '0;
      count_q <= '0;
    end else if (update_i && pass_i) begin
      count_q <= count_q + 1'b1;
      high_q  <= tap_i;
      if (low_q == NO_PASS) low_q <= MARK_W'(tap_i);
    end
  end

  assign span_sum = {1'b0, low_q[TAP_W-1:0]} + {1'b0, high_q};

  always_comb begin
    final_o = FALLBACK;
    if (count_q != '0) final_o = span_sum[TAP_W:1];
  end

  assign count_o = count_q;

  // R7: marker stays until a pass is recorded
  assert_marker_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |-> (low_q == NO_PASS));

  // R6: recorded bounds are ordered and the low bound is a real tap
  assert_bounds_ordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0) |-> (low_q[MARK_W-1:TAP_W] == '0 && high_q >= low_q[TAP_W-1:0]));
endmodule

// File: rtl/tap_cal_lanes.sv
module tap_cal_lanes #(
  parameter int LANES = 4,
  parameter int TAP_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [TAP_W-1:0]       tap_i,
  output logic [LANES*TAP_W-1:0] taps_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [TAP_W-1:0] setting_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      setting_q <= '0;
      else if (load_i) setting_q <= tap_i;
    end
    assign taps_o[g*TAP_W +: TAP_W] = setting_q;
  end
endmodule

// File: rtl/tap_cal_seq.sv
module tap_cal_seq import tap_cal_pkg::*; #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bist_done_i,
  output logic             clear_o,
  output logic             lane_load_o,
  output logic             use_final_o,
  output logic             capture_o,
  output logic             judge_o,
  output logic             bist_start_o,
  output logic             done_o,
  output logic             valid_o,
  output logic [TAP_W-1:0] tap_o
);
  localparam logic [TAP_W-1:0] LAST_TAP = {TAP_W{1'b1}};

  seq_state_t       state_q, state_d;
  logic [TAP_W-1:0] tap_q;
  logic             launch_q;
  logic             done_q;
  logic             valid_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_APPLY;
      ST_APPLY: state_d = ST_ARM;
      ST_ARM:   state_d = ST_RUN;
      ST_RUN:   if (bist_done_i) state_d = ST_JUDGE;
      ST_JUDGE: state_d = (tap_q == LAST_TAP) ? ST_FINAL : ST_APPLY;
      ST_FINAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign clear_o     = (state_q == ST_IDLE) && start_i;
  assign lane_load_o = (state_q == ST_APPLY) || (state_q == ST_FINAL);
  assign use_final_o = (state_q == ST_FINAL);
  assign capture_o   = (state_q == ST_RUN) && bist_done_i;
  assign judge_o     = (state_q == ST_JUDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tap_q    <= '0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_FINAL);
      if (clear_o) begin
        tap_q   <= '0;
        valid_q <= 1'b0;
      end else if (state_q == ST_JUDGE && tap_q != LAST_TAP) begin
        tap_q <= tap_q + 1'b1;
      end
      if (state_q == ST_FINAL) valid_q <= 1'b1;
      if (state_q == ST_ARM)       launch_q <= 1'b1;
      else if (capture_o)          launch_q <= 1'b0;
    end
  end

  assign bist_start_o = launch_q;
  assign done_o       = done_q;
  assign valid_o      = valid_q;
  assign tap_o        = tap_q;

  // R3: launch level released right after the done bit
  assert_launch_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_q && bist_done_i) |=> !launch_q);

  // R1: tap steps by exactly one after each non-final judgement
  assert_tap_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_JUDGE && tap_q != LAST_TAP) |=> (tap_q == $past(tap_q) + 1'b1));

  // R1: sweep finishes only after the last tap
  assert_sweep_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_JUDGE && tap_q == LAST_TAP) |=> (state_q == ST_FINAL));

  // R11: a start during a sweep never restarts the tap
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> (tap_q != '0 || $past(tap_q) == '0));
endmodule

// File: rtl/tap_sweep_cal.sv
module tap_sweep_cal #(
  parameter int LANES       = 4,
  parameter int TAP_W       = 6,
  parameter int CNT_W       = 8,
  parameter int DEFAULT_TAP = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [CNT_W:1]         run_cfg_i,
  input  logic [2*CNT_W:0]       bist_status_i,
  output logic                   bist_start_o,
  output logic [LANES*TAP_W-1:0] lane_tap_o,
  output logic                   done_o,
  output logic                   result_valid_o,
  output logic [TAP_W:0]         pass_count_o
);
  localparam logic [TAP_W-1:0] FALLBACK = TAP_W'(DEFAULT_TAP);

  logic             clear, lane_load, use_final, capture, judge;
  logic [TAP_W-1:0] cur_tap, final_tap, lane_src;
  logic [CNT_W-1:0] runs_q;
  logic [2*CNT_W-1:0] counts_q;
  logic             tap_pass;
  logic             lanes_match;

  tap_cal_seq #(.TAP_W(TAP_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .bist_done_i  (bist_status_i[0]),
    .clear_o      (clear),
    .lane_load_o  (lane_load),
    .use_final_o  (use_final),
    .capture_o    (capture),
    .judge_o      (judge),
    .bist_start_o (bist_start_o),
    .done_o       (done_o),
    .valid_o      (result_valid_o),
    .tap_o        (cur_tap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runs_q   <= '0;
      counts_q <= '0;
    end else begin
      if (clear)   runs_q   <= run_cfg_i;
      if (capture) counts_q <= bist_status_i[2*CNT_W:1];
    end
  end

  tap_cal_judge #(.CNT_W(CNT_W)) u_judge (
    .counts_i (counts_q),
    .runs_i   (runs_q),
    .pass_o   (tap_pass)
  );

  tap_cal_window #(.TAP_W(TAP_W), .DEFAULT_TAP(DEFAULT_TAP)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear),
    .update_i (judge),
    .pass_i   (tap_pass),
    .tap_i    (cur_tap),
    .count_o  (pass_count_o),
    .final_o  (final_tap)
  );

  assign lane_src = use_final ? final_tap : cur_tap;

  tap_cal_lanes #(.LANES(LANES), .TAP_W(TAP_W)) u_lanes (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (lane_load),
    .tap_i  (lane_src),
    .taps_o (lane_tap_o)
  );

  always_comb begin
    lanes_match = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (lane_tap_o[i*TAP_W +: TAP_W] != cur_tap) lanes_match = 1'b0;
  end

  // R2: every lane carries the tap under test when a self-test launches
  assert_lanes_at_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_start_o) |-> lanes_match);

  // R9: empty window leaves the fallback tap
  assert_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pass_count_o == '0) |-> (lane_tap_o[TAP_W-1:0] == FALLBACK));

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: result held steady while valid and no new start
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && !start_i) |=> $stable(lane_tap_o));
endmodule

// File: tb/tap_sweep_cal_test.sv
module tap_sweep_cal_test;
  localparam int LANES = 4;
  localparam int TAP_W = 6;
  localparam int CNT_W = 8;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   start_i = 1'b0;
  logic [CNT_W:1]         run_cfg_i = '0;
  logic [2*CNT_W:0]       bist_status_i = '0;
  logic                   bist_start_o;
  logic [LANES*TAP_W-1:0] lane_tap_o;
  logic                   done_o;
  logic                   result_valid_o;
  logic [TAP_W:0]         pass_count_o;

  tap_sweep_cal uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_cfg_i(run_cfg_i),
    .bist_status_i(bist_status_i), .bist_start_o(bist_start_o),
    .lane_tap_o(lane_tap_o), .done_o(done_o),
    .result_valid_o(result_valid_o), .pass_count_o(pass_count_o)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  int win_lo, win_hi, mode;
  logic [7:0] runs;
  int exp_tap, tests_seen, lat, model_tap;
  bit active = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane(input int i);
    return int'(lane_tap_o[i*TAP_W +: TAP_W]);
  endfunction

  function automatic logic [2*CNT_W:0] make_status(input int t);
    if (t >= win_lo && t <= win_hi) return {8'd0, runs, 1'b1};
    if (mode == 0) return {8'(t + 1), runs, 1'b1};
    return {8'd0, runs + 8'd1, 1'b1};
  endfunction

  // Self-test model
  always @(negedge clk) begin
    if (!rst_n) begin
      bist_status_i = '0;
      active = 1'b0;
    end else if (!bist_start_o) begin
      if (active && !bist_status_i[0]) check(1'b0, "R3 launch dropped early", 0, 1);
      active = 1'b0;
      bist_status_i = '0;
    end else if (!active) begin
      bit same;
      active = 1'b1;
      model_tap = lane(0);
      same = 1'b1;
      for (int i = 1; i < LANES; i++) if (lane(i) != model_tap) same = 1'b0;
      check(same, "R2 lanes differ at launch", lane(LANES-1), model_tap);
      check(model_tap == exp_tap, "R1 tap order", model_tap, exp_tap);
      exp_tap++;
      tests_seen++;
      lat = 1 + model_tap % 3;
    end else if (lat > 0) begin
      lat--;
    end else if (!bist_status_i[0]) begin
      bist_status_i = make_status(model_tap);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      misses++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic run_cal(input int lo, input int hi, input int md, input int rn, input bit mid_pulse);
    int waited, cnt, fin;
    bit same;
    win_lo = lo; win_hi = hi; mode = md; runs = 8'(rn);
    exp_tap = 0; tests_seen = 0;
    @(negedge clk);
    run_cfg_i = 8'(rn);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    run_cfg_i = ~8'(rn);  // R4: late change must be ignored
    waited = 0;
    while (!done_o && waited < 5000) begin
      @(negedge clk);
      waited++;
      start_i = (mid_pulse && waited == 100);
    end
    start_i = 1'b0;
    if (!done_o) begin
      check(1'b0, "R10 done missing", 0, 1);
      return;
    end
    cnt = (lo > hi) ? 0 : hi - lo + 1;
    fin = (cnt != 0) ? (lo + hi) / 2 : 8;
    check(tests_seen == 64, mid_pulse ? "R11 sweep length with start mid-run" : "R1 sweep length",
          tests_seen, 64);
    check(int'(pass_count_o) == cnt, "R6 pass count (R4 R5 rule)", int'(pass_count_o), cnt);
    check(lane(0) == fin, (cnt != 0) ? "R8 midpoint tap" : "R9 fallback tap", lane(0), fin);
    same = 1'b1;
    for (int i = 0; i < LANES; i++) if (lane(i) != fin) same = 1'b0;
    check(same, "R10 final on all lanes", lane(LANES-1), fin);
    check(result_valid_o == 1'b1, "R10 result valid", int'(result_valid_o), 1);
    @(negedge clk);
    check(done_o == 1'b0, "R10 done one cycle", int'(done_o), 0);
    repeat (5) @(negedge clk);
    same = 1'b1;
    for (int i = 0; i < LANES; i++) if (lane(i) != fin) same = 1'b0;
    check(same && result_valid_o && int'(pass_count_o) == cnt, "R10 result held", lane(0), fin);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 1'b0, "R10 reset done", int'(done_o), 0);
    check(result_valid_o == 1'b0, "R10 reset valid", int'(result_valid_o), 0);
    check(bist_start_o == 1'b0, "R3 reset launch", int'(bist_start_o), 0);
    check(lane_tap_o == '0, "R2 reset lanes", int'(lane_tap_o), 0);

    run_cal(0, 63, 0, 8, 1'b0);     // full window
    run_cal(0, 0, 1, 255, 1'b0);    // R7: window at tap 0
    run_cal(63, 63, 0, 1, 1'b0);    // single top tap
    run_cal(10, 5, 0, 20, 1'b0);    // R9: nothing passes (fail counts)
    run_cal(40, 39, 1, 165, 1'b0);  // R5: nothing passes (run mismatch)
    run_cal(20, 40, 1, 0, 1'b1);    // R11: start during sweep
    run_cal(7, 8, 0, 3, 1'b0);      // R6: clears after previous run
    for (int lo = 0; lo < 64; lo += 9)
      for (int hi = lo; hi < 64; hi += 11)
        run_cal(lo, hi, (lo + hi) % 2, (lo * 7 + hi) % 256, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule